// File: doc/BRIEF.md
# Dual-Channel Transmit Queue

This block holds two independent transmit byte queues that software fills through a single 32-bit data register. A channel-select register decides which queue the data register feeds. Each channel has its own frame length register and its own start register. Once a start is taken, the block sends that channel's frame out of a byte-wide valid/ready stream, one byte per accepted beat. It then empties the channel's queue, zeroes its length and sets that channel's completion interrupt bit.

Both channels share one output stream. A start taken while the other channel is sending waits until that frame has ended, so frames never interleave. Line coding, checksum generation and collision handling happen downstream and are not part of this block.

Top module: `dual_txq`

## Requirements
- R1: After reset, `tx_valid` is low, `tx_irq` is 0, both queues are empty, both lengths are 0 and transmit enable is off.
- R2: A data write (address 2) adds four bytes to the selected queue, starting with bits 7:0 and ending with bits 31:24. Bytes leave a queue in the order they were written. The channel-select register (address 1) selects channel 1 only when it is written with exactly 1. Any other value selects channel 0.
- R3: Each queue holds 2048 bytes. A data write is dropped when the selected queue has fewer than 4 bytes free.
- R4: A length write (address 3 for channel 0, address 4 for channel 1) with a value above 2048 stores 2048.
- R5: Writing 1 to bit 0 of a start register (address 5 for channel 0, address 6 for channel 1) takes the start only when the enable bit (address 0, bit 0) is set and that channel is neither waiting nor sending. Otherwise the write has no effect.
- R6: The number of bytes sent is the smaller of the channel's length and the bytes in its queue, both taken at the moment the start is accepted. When that number is zero, no beat is sent.
- R7: `tx_valid` first rises on the second clock edge after an accepted start when the output is free. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady. `tx_last` marks the final byte of a frame, and at least one idle cycle follows every frame.
- R8: A frame completes on the edge of its final handshake, or one edge after launch for a zero-byte frame. On completion the channel's queue is emptied, its length becomes 0 and `tx_irq` bit 0 (channel 0) or bit 1 (channel 1) is set.
- R9: A start taken while the other channel is sending is served after that frame ends. Frames from the two channels never interleave.
- R10: Writing to address 7 clears each `tx_irq` bit whose data bit is 1. If a completion sets a bit in the same cycle that a write clears it, the bit ends up set.
- R11: A write to address 0 with bit 1 set empties both queues, clears both lengths and drops any waiting or running frame without setting an interrupt bit. The same write loads the enable bit from data bit 0.
- R12: When a channel completes in the same cycle as a data write or a length write to that channel, the completion wins: the queue ends up empty and the length ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| tx_valid | output | 1 | Output byte is valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_irq | output | 2 | Per-channel completion status |

## Verification
The bench targets these corner cases:

- **Channel-select value of 5.** A design that kept the raw value would steer the data into channel 1.
- **Length of 5000 with a full queue.** A design that truncated the length instead of clamping it would send 904 bytes instead of 2048.
- **513th word into a full queue.** A design without the full check would overwrite unsent bytes.
- **Start with the queue or length already cleared.** Repeating a start after completion, or starting with no new length, must produce a zero-byte frame. A design that did not clear the queue or length on completion would resend old data.
- **Start while disabled or busy.** A design that ignored the busy check would send the frame twice.
- **Soft reset mid-frame.** A design that handled soft reset wrongly would keep streaming or raise an interrupt.
- **Same-cycle collisions.** Random traffic forces completions to collide with clears, pushes and length writes. A design with the wrong priority would keep stale bytes or lose an interrupt.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned REG_AW      = 3;
    localparam int unsigned WORD_BYTES  = 4;
    localparam int unsigned NUM_CH      = 2;
    localparam int unsigned EN_BIT      = 0;
    localparam int unsigned SRST_BIT    = 1;
    localparam int unsigned GO_BIT      = 0;

    typedef enum logic [REG_AW-1:0] {
        A_GLOBAL = 3'd0,
        A_CHSEL  = 3'd1,
        A_DATA   = 3'd2,
        A_LEN0   = 3'd3,
        A_LEN1   = 3'd4,
        A_GO0    = 3'd5,
        A_GO1    = 3'd6,
        A_IRQCLR = 3'd7
    } reg_addr_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } tx_beat_t;

    // Only the exact value 1 picks the second channel.
    function automatic logic decode_sel(input logic [31:0] v);
        return (v == 32'd1);
    endfunction

    function automatic logic [31:0] clamp_len(input logic [31:0] v,
                                              input logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned LEN_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [31:0]      push_word,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [LEN_W-1:0] count
);
    localparam int unsigned WORDS = DEPTH / 4;
    localparam int unsigned WA    = $clog2(WORDS);
    localparam int unsigned BA    = $clog2(DEPTH);

    logic [31:0]      mem [WORDS];
    logic [WA-1:0]    wr_ptr;
    logic [BA-1:0]    rd_ptr;
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + WA'(1);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + BA'(1);
            end
            cnt_q <= cnt_q + (push ? LEN_W'(4) : LEN_W'(0)) - (pop ? LEN_W'(1) : LEN_W'(0));
        end
    end

    logic [31:0] head_word;
    always_comb begin
        head_word = mem[rd_ptr[BA-1:2]];
        head      = head_word[8*rd_ptr[1:0] +: 8];
    end

    assign count = cnt_q;

endmodule

// File: rtl/txq_regs.sv
module txq_regs
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned LEN_W = $clog2(DEPTH) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [1:0][LEN_W-1:0] fifo_cnt,
    input  logic                  done,
    input  logic                  done_ch,
    output logic [1:0]            push,
    output logic [1:0]            flush,
    output logic                  sreset,
    output logic [1:0]            pend,
    output logic [1:0][LEN_W-1:0] send_cnt,
    output logic [1:0]            irq
);
    localparam logic [31:0]      DEPTH_W  = 32'(DEPTH);
    localparam logic [LEN_W-1:0] FULL_LIM = LEN_W'(DEPTH - WORD_BYTES);

    logic                  tx_en;
    logic                  ch_sel;
    logic [1:0][LEN_W-1:0] len_q;
    logic [1:0][LEN_W-1:0] cnt_q;
    logic [1:0]            pend_q;
    logic [1:0]            irq_q;

    logic       is_global, is_sel, is_data, is_clr;
    logic [1:0] is_len, is_go, go_ok, done_vec;

    always_comb begin
        is_global = wr_en && (wr_addr == A_GLOBAL);
        is_sel    = wr_en && (wr_addr == A_CHSEL);
        is_data   = wr_en && (wr_addr == A_DATA);
        is_clr    = wr_en && (wr_addr == A_IRQCLR);
        is_len[0] = wr_en && (wr_addr == A_LEN0);
        is_len[1] = wr_en && (wr_addr == A_LEN1);
        is_go[0]  = wr_en && (wr_addr == A_GO0);
        is_go[1]  = wr_en && (wr_addr == A_GO1);
        done_vec  = done ? (done_ch ? 2'b10 : 2'b01) : 2'b00;
    end

    assign sreset = is_global && wr_data[SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en  <= 1'b0;
            ch_sel <= 1'b0;
        end else begin
            if (is_global) begin
                tx_en <= wr_data[EN_BIT];
            end
            if (is_sel) begin
                ch_sel <= decode_sel(wr_data);
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign push[c]  = is_data && (ch_sel == 1'(c)) && (fifo_cnt[c] <= FULL_LIM);
        assign go_ok[c] = is_go[c] && wr_data[GO_BIT] && tx_en && !pend_q[c];
        assign flush[c] = done_vec[c] || sreset;

        always_ff @(posedge clk) begin
            if (rst || sreset) begin
                len_q[c]  <= '0;
                cnt_q[c]  <= '0;
                pend_q[c] <= 1'b0;
            end else if (done_vec[c]) begin
                len_q[c]  <= '0;
                pend_q[c] <= 1'b0;
            end else begin
                if (is_len[c]) begin
                    len_q[c] <= LEN_W'(clamp_len(wr_data, DEPTH_W));
                end
                if (go_ok[c]) begin
                    pend_q[c] <= 1'b1;
                    cnt_q[c]  <= (len_q[c] < fifo_cnt[c]) ? len_q[c] : fifo_cnt[c];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                irq_q[c] <= 1'b0;
            end else if (done_vec[c] && !sreset) begin
                irq_q[c] <= 1'b1;
            end else if (is_clr && wr_data[c]) begin
                irq_q[c] <= 1'b0;
            end
        end
    end

    assign pend     = pend_q;
    assign send_cnt = cnt_q;
    assign irq      = irq_q;

endmodule

// File: rtl/txq_seq.sv
module txq_seq
    import txq_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  abort,
    input  logic [1:0]            pend,
    input  logic [1:0][LEN_W-1:0] send_cnt,
    input  logic                  tx_ready,
    output logic                  busy,
    output logic                  ch,
    output logic                  last,
    output logic [1:0]            pop,
    output logic                  done,
    output logic                  done_ch
);
    seq_state_e       state;
    logic             ch_q;
    logic [LEN_W-1:0] rem;

    logic pick, hs, launch, zero_len;

    always_comb begin
        pick     = !pend[0];
        hs       = (state == S_SEND) && tx_ready;
        launch   = (state == S_IDLE) && (|pend);
        zero_len = (send_cnt[pick] == '0);
        last     = (state == S_SEND) && (rem == LEN_W'(1));
        done     = (hs && last) || (launch && zero_len);
        done_ch  = (state == S_SEND) ? ch_q : pick;
        pop      = hs ? (ch_q ? 2'b10 : 2'b01) : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= S_IDLE;
            ch_q  <= 1'b0;
            rem   <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (launch && !zero_len) begin
                        state <= S_SEND;
                        ch_q  <= pick;
                        rem   <= send_cnt[pick];
                    end
                end
                S_SEND: begin
                    if (hs) begin
                        rem <= rem - LEN_W'(1);
                        if (last) begin
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state == S_SEND);
    assign ch   = ch_q;

endmodule

// File: rtl/dual_txq.sv
module dual_txq
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic [1:0]        tx_irq
);
    localparam int unsigned LEN_W = $clog2(DEPTH) + 1;

    logic [1:0][LEN_W-1:0] fifo_count;
    logic [1:0][LEN_W-1:0] send_cnt;
    logic [1:0][7:0]       head_b;
    logic [1:0]            push, flush, pop, pend;
    logic                  sreset, done, done_ch, busy, ch, last_flag;
    tx_beat_t              beat;

    txq_regs #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fifo_cnt (fifo_count),
        .done     (done),
        .done_ch  (done_ch),
        .push     (push),
        .flush    (flush),
        .sreset   (sreset),
        .pend     (pend),
        .send_cnt (send_cnt),
        .irq      (tx_irq)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_q
        txq_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush[c]),
            .push      (push[c]),
            .push_word (wr_data),
            .pop       (pop[c]),
            .head      (head_b[c]),
            .count     (fifo_count[c])
        );
    end

    txq_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .abort    (sreset),
        .pend     (pend),
        .send_cnt (send_cnt),
        .tx_ready (tx_ready),
        .busy     (busy),
        .ch       (ch),
        .last     (last_flag),
        .pop      (pop),
        .done     (done),
        .done_ch  (done_ch)
    );

    always_comb begin
        beat.valid = busy;
        beat.data  = head_b[ch];
        beat.last  = last_flag;
    end

    assign tx_valid = beat.valid;
    assign tx_data  = beat.data;
    assign tx_last  = beat.last;

endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic [1:0]       tx_irq,
    input logic             sreset,
    input logic [LEN_W-1:0] cnt0,
    input logic [LEN_W-1:0] cnt1
);
    localparam logic [LEN_W-1:0] LIM = LEN_W'(DEPTH);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !sreset) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt0 <= LIM) && (cnt1 <= LIM));

    p_irq_on_end_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last && !sreset) |=> (tx_irq != 2'b00));

    p_empty_on_end_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> ((cnt0 == '0) || (cnt1 == '0)));

    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        sreset |=> (!tx_valid && (cnt0 == '0) && (cnt1 == '0)));

endmodule

bind dual_txq txq_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_irq   (tx_irq),
    .sreset   (sreset),
    .cnt0     (fifo_count[0]),
    .cnt1     (fifo_count[1])
);

// File: tb/tb_dual_txq.sv
module tb_dual_txq;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_ready = 1'b0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic [1:0]  tx_irq;

    dual_txq #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_irq(tx_irq)
    );

    always #4 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    ended = 0;
    bit    live = 0;
    int    ready_mode = 0;
    string phase = "R1";

    // reference model state
    logic [7:0] mq [2][$];
    int  m_len [2];
    int  m_cnt [2];
    bit  m_pend [2];
    bit  m_en, m_sel, m_busy, m_ch;
    int  m_rem;
    bit [1:0] m_irq;

    // observed frames
    int         frames[$];
    logic [7:0] fbytes[$];
    int         beats = 0;
    bit         pv = 0, plast = 0;
    logic [7:0] pdata = 0;

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (phase %s)", tag, act, exp, phase);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 190000);
            finish_run();
        end
    end

    always @(negedge clk) begin
        #1;
        case (ready_mode)
            0: tx_ready = 1'b0;
            1: tx_ready = 1'b1;
            default: tx_ready = 1'($urandom_range(0, 1));
        endcase
    end

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                mq[c].delete();
                m_len[c] = 0; m_cnt[c] = 0; m_pend[c] = 0;
            end
            m_en = 0; m_sel = 0; m_busy = 0; m_ch = 0; m_rem = 0; m_irq = 0;
        end else begin
            int  sz_old [2];
            bit  pend_old [2];
            bit  done, dch, sres;
            done = 0; dch = 0; sres = 0;
            for (int c = 0; c < 2; c++) begin
                sz_old[c]   = mq[c].size();
                pend_old[c] = m_pend[c];
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_en = wr_data[0]; sres = wr_data[1]; end
                    3'd1: m_sel = (wr_data == 32'd1);
                    3'd2: if (sz_old[m_sel] <= DEPTH - 4)
                              for (int b = 0; b < 4; b++) mq[m_sel].push_back(wr_data[8*b +: 8]);
                    3'd3, 3'd4: m_len[wr_addr - 3] = (wr_data > DEPTH) ? DEPTH : int'(wr_data);
                    3'd5, 3'd6: begin
                        int c;
                        c = wr_addr - 5;
                        if (wr_data[0] && m_en && !pend_old[c]) begin
                            m_pend[c] = 1;
                            m_cnt[c]  = (m_len[c] < sz_old[c]) ? m_len[c] : sz_old[c];
                        end
                    end
                    default: m_irq = m_irq & ~wr_data[1:0];
                endcase
            end
            if (m_busy) begin
                if (tx_ready) begin
                    void'(mq[m_ch].pop_front());
                    m_rem--;
                    if (m_rem == 0) begin done = 1; dch = m_ch; m_busy = 0; end
                end
            end else if (pend_old[0] || pend_old[1]) begin
                bit c;
                c = !pend_old[0];
                if (m_cnt[c] == 0) begin done = 1; dch = c; end
                else begin m_busy = 1; m_ch = c; m_rem = m_cnt[c]; end
            end
            if (sres) begin
                for (int c = 0; c < 2; c++) begin
                    mq[c].delete(); m_len[c] = 0; m_cnt[c] = 0; m_pend[c] = 0;
                end
                m_busy = 0;
            end else if (done) begin
                mq[dch].delete();
                m_len[dch] = 0;
                m_pend[dch] = 0;
                m_irq[dch] = 1;
            end
        end
    end

    // per-cycle comparison and frame recording, away from the rising edge
    always @(negedge clk) begin
        if (rst) begin
            pv = 0; plast = 0;
        end else if (live) begin
            report(tx_valid == m_busy, "R6/R9 tx_valid", int'(tx_valid), int'(m_busy));
            if (m_busy) begin
                report(tx_data == mq[m_ch][0], "R2 tx_data", int'(tx_data), int'(mq[m_ch][0]));
                report(tx_last == (m_rem == 1), "R7 tx_last", int'(tx_last), int'(m_rem == 1));
            end
            report(tx_irq == m_irq, "R8/R10 tx_irq", int'(tx_irq), int'(m_irq));
            if (pv && tx_ready) begin
                if (beats == 0) fbytes.push_back(pdata);
                beats++;
                if (plast) begin frames.push_back(beats); beats = 0; end
            end
            pv = tx_valid; pdata = tx_data; plast = tx_last;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic quiet();
        int idle = 0;
        for (int i = 0; i < 6000 && idle < 3; i++) begin
            @(negedge clk);
            if (!m_busy && !m_pend[0] && !m_pend[1]) idle++;
            else idle = 0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic clr_rec();
        frames.delete(); fbytes.delete(); beats = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        live = 1;
        @(negedge clk);
        // R1 reset state
        report(tx_valid == 1'b0, "R1 valid after reset", int'(tx_valid), 0);
        report(tx_irq == 2'b00, "R1 irq after reset", int'(tx_irq), 0);

        // R2: channel 1, LSB first; R6 length below queue content
        phase = "R2";
        ready_mode = 1;
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd1);
        wr(3'd2, 32'h44332211);
        wr(3'd2, 32'h88776655);
        wr(3'd4, 32'd6);
        clr_rec();
        wr(3'd6, 32'd1);
        quiet();
        report(frames.size() == 1 && frames[0] == 6, "R6 frame length ch1",
               frames.size() ? frames[0] : -1, 6);
        report(fbytes.size() == 1 && fbytes[0] == 8'h11, "R2 first byte",
               fbytes.size() ? int'(fbytes[0]) : -1, 8'h11);
        report(tx_irq == 2'b10, "R8 irq bit 1", int'(tx_irq), 2);

        // R2: select value 5 maps to channel 0
        wr(3'd7, 32'd3);
        wr(3'd1, 32'd5);
        wr(3'd2, 32'hA1B2C3D4);
        wr(3'd3, 32'd4);
        ready_mode = 2;
        clr_rec();
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 1 && frames[0] == 4, "R2 select 5 frame length",
               frames.size() ? frames[0] : -1, 4);
        report(fbytes.size() == 1 && fbytes[0] == 8'hD4, "R2 select 5 first byte",
               fbytes.size() ? int'(fbytes[0]) : -1, 8'hD4);
        report(tx_irq == 2'b01, "R8 irq bit 0", int'(tx_irq), 1);

        // R6: length larger than content
        phase = "R6";
        wr(3'd2, 32'h01020304);
        wr(3'd2, 32'h05060708);
        wr(3'd3, 32'd100);
        clr_rec();
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 1 && frames[0] == 8, "R6 limited by queue",
               frames.size() ? frames[0] : -1, 8);

        // R8: queue emptied, then length cleared
        phase = "R8";
        wr(3'd7, 32'd3);
        wr(3'd3, 32'd4);
        clr_rec();
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 0 && beats == 0, "R8 queue emptied after send", beats, 0);
        report(tx_irq == 2'b01, "R6 zero frame sets irq", int'(tx_irq), 1);
        wr(3'd2, 32'hCAFEF00D);
        clr_rec();
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 0 && beats == 0, "R8 length cleared after send", beats, 0);

        // R5: enable off blocks start
        phase = "R5";
        wr(3'd0, 32'd0);
        wr(3'd7, 32'd3);
        wr(3'd2, 32'h11111111);
        wr(3'd3, 32'd4);
        clr_rec();
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 0 && tx_irq == 2'b00, "R5 start while disabled",
               int'(tx_irq), 0);
        wr(3'd0, 32'd1);
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 1 && frames[0] == 4, "R5 start after enable",
               frames.size() ? frames[0] : -1, 4);

        // R5: start while busy ignored
        ready_mode = 0;
        wr(3'd2, 32'h22222222);
        wr(3'd2, 32'h33333333);
        wr(3'd3, 32'd8);
        clr_rec();
        wr(3'd5, 32'd1);
        wr(3'd3, 32'd8);
        wr(3'd5, 32'd1);
        ready_mode = 2;
        quiet();
        report(frames.size() == 1, "R5 repeated start while busy", frames.size(), 1);

        // R9: second channel waits
        phase = "R9";
        ready_mode = 0;
        wr(3'd1, 32'd0);
        wr(3'd2, 32'h44444444);
        wr(3'd2, 32'h55555555);
        wr(3'd3, 32'd8);
        clr_rec();
        wr(3'd5, 32'd1);
        wr(3'd1, 32'd1);
        wr(3'd2, 32'h66666666);
        wr(3'd4, 32'd4);
        wr(3'd6, 32'd1);
        ready_mode = 1;
        quiet();
        report(frames.size() == 2 && frames[0] == 8 && frames[1] == 4, "R9 frame order",
               frames.size() ? frames[0] : -1, 8);
        report(tx_irq == 2'b11, "R9 both irq bits", int'(tx_irq), 3);

        // R10: selective clear
        phase = "R10";
        wr(3'd7, 32'd2);
        report(tx_irq == 2'b01, "R10 clear bit 1 only", int'(tx_irq), 1);
        wr(3'd7, 32'd1);
        report(tx_irq == 2'b00, "R10 clear bit 0", int'(tx_irq), 0);

        // R3/R4: fill past capacity, length beyond capacity
        phase = "R3";
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd5000);
        for (int i = 0; i < 513; i++) wr(3'd2, 32'(i * 32'h01010101));
        clr_rec();
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 1 && frames[0] == 2048, "R3/R4 full queue send",
               frames.size() ? frames[0] : -1, 2048);

        // R11: soft reset during a frame
        phase = "R11";
        wr(3'd7, 32'd3);
        ready_mode = 0;
        wr(3'd2, 32'h77777777);
        wr(3'd2, 32'h88888888);
        wr(3'd3, 32'd8);
        wr(3'd5, 32'd1);
        ready_mode = 2;
        repeat (3) @(negedge clk);
        wr(3'd0, 32'd3);
        quiet();
        report(tx_irq == 2'b00 && tx_valid == 1'b0, "R11 abort without irq", int'(tx_irq), 0);
        wr(3'd3, 32'd8);
        clr_rec();
        wr(3'd5, 32'd1);
        quiet();
        report(frames.size() == 0 && beats == 0, "R11 queue emptied", beats, 0);
        report(tx_irq == 2'b01, "R11 enable kept from bit 0", int'(tx_irq), 1);

        // R12/R10: random traffic for same-cycle collisions
        phase = "R12";
        ready_mode = 2;
        for (int i = 0; i < 3000; i++) begin
            int a;
            logic [31:0] d;
            a = $urandom_range(0, 7);
            if (a == 2 || a >= 5) a = $urandom_range(0, 3) == 0 ? a : (a == 2 ? 2 : 5 + (a & 1));
            case (a)
                0: d = ($urandom_range(0, 15) == 0) ? 32'd3 : 32'd1;
                1: d = 32'($urandom_range(0, 3));
                2: d = $urandom;
                3, 4: d = ($urandom_range(0, 9) == 0) ? 32'd3000 : 32'($urandom_range(0, 24));
                7: d = 32'($urandom_range(0, 3));
                default: d = 32'd1;
            endcase
            wr(3'(a), d);
        end
        quiet();
        report(tx_valid == 1'b0, "R12 idle after random traffic", int'(tx_valid), 0);

        finish_run();
    end

endmodule